// File: doc/BRIEF.md
# Clock Frequency Meter

The meter compares one of several monitored clocks against the block's own clock, which acts as a free-running reference. A controller picks the monitored clock, writes a window length in monitored-clock cycles and sets a start bit. A separate bit lets the reference count advance. The meter counts reference cycles for as long as the monitored clock takes to complete the window. It then holds that count in a result word that can be read back. The controller works out the monitored frequency as reference frequency × window / result.

Each monitored clock has its own window counter, which runs in that clock's domain. The start request enters that domain through two flip-flops, and the finish flag comes back into the reference domain through two more. A result of zero means no measurement has completed yet. Registers are reached over a small word-addressed 32-bit bus. A write takes effect on the clock edge, and read data is combinational from the address.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset, the control word (address 0), the result word (address 1) and the reference-enable word (address 2) all read as zero.
- R2: The control word holds the monitor select in bits 27:26, the start/enable bit in bit 24 and the window length in bits 23:0. The reference-enable word holds its enable in bit 8. All other bits of both words read as zero.
- R3: With the reference enabled, a measurement of N monitored cycles of period Tm publishes a result within Tm/Tc+3 of ((2N+3)·Tm)/(2·Tc)+1, where Tc is the reference period. This allowance covers the two synchronizer crossings.
- R4: Select value k (0..3) times monitored clock k. Only the selected clock's window counter may finish.
- R5: A 0-to-1 write of the enable bit starts a measurement and clears the result to zero at once. The result stays zero until the window completes.
- R6: Clearing the enable bit stops the measurement and resets the counters. The last result keeps its value until the next start.
- R7: With the reference-enable bit clear, the reference count does not advance, so a completed window leaves the result at zero.
- R8: The reference count saturates at all ones (RES_W bits) and does not wrap. A window longer than that range publishes the all-ones value.
- R9: A window length of zero, or a selected monitored clock that never toggles, never completes, and the result stays zero.
- R10: Writes to the result word have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also clocks the register bus |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| mon_clk | input | NUM_MON | Monitored clocks, one per select value |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Word address: 0 control, 1 result, 2 reference enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |

## Verification
The hardest state to reach is the saturated reference count. With the default width it would need billions of cycles. The bench therefore builds the meter with a 10-bit result and selects the slowest monitored clock with a 300-cycle window, so the true count of roughly 1500 passes the 1023 ceiling. The bench cannot know the exact crossing latency of asynchronous clocks. It therefore compares each normal result against a band derived from the clock periods, and uses three monitored clocks of different speeds so that a wrong select gives a result outside the band.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int NUM_MON  = 4;
  localparam int SEL_W    = $clog2(NUM_MON);
  localparam int WIN_W    = 24;
  localparam int SEL_LSB  = 26;
  localparam int RUN_BIT  = 24;
  localparam int REFEN_BIT = 8;
  localparam int ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_RESULT = 2'd1,
    A_REFEN  = 2'd2
  } fm_addr_e;

  // True on the count value that closes a window of 'len' cycles.
  function automatic logic window_last(logic [WIN_W-1:0] cnt, logic [WIN_W-1:0] len);
    return (len != '0) && (cnt == len - WIN_W'(1));
  endfunction
endpackage

// File: rtl/fm_sync2.sv
module fm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fm_window.sv
module fm_window
  import fm_pkg::*;
(
  input  logic             mon_clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_done
);
  logic             arm_s;
  logic [WIN_W-1:0] cnt;

  fm_sync2 u_arm_sync (.clk(mon_clk), .rst_n(rst_n), .d(arm), .q(arm_s));

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      win_done <= 1'b0;
    end else if (!arm_s) begin
      cnt      <= '0;
      win_done <= 1'b0;
    end else if (!win_done) begin
      if (window_last(cnt, win_len)) win_done <= 1'b1;
      cnt <= cnt + WIN_W'(1);
    end
  end
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [RES_W-1:0]  result,
  output logic [31:0]       bus_rdata,
  output logic [SEL_W-1:0]  sel,
  output logic              det_en,
  output logic [WIN_W-1:0]  win_len,
  output logic              ref_en,
  output logic              start_pulse
);
  logic wr_ctrl, wr_refen;
  logic unused_wbits;

  assign wr_ctrl     = bus_en && bus_we && (bus_addr == A_CTRL);
  assign wr_refen    = bus_en && bus_we && (bus_addr == A_REFEN);
  assign start_pulse = wr_ctrl && bus_wdata[RUN_BIT] && !det_en;
  assign unused_wbits = ^{bus_wdata[31:SEL_LSB+SEL_W], bus_wdata[RUN_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel     <= '0;
      det_en  <= 1'b0;
      win_len <= '0;
      ref_en  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        sel     <= bus_wdata[SEL_LSB +: SEL_W];
        det_en  <= bus_wdata[RUN_BIT];
        win_len <= bus_wdata[WIN_W-1:0];
      end
      if (wr_refen) ref_en <= bus_wdata[REFEN_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[SEL_LSB +: SEL_W] = sel;
        bus_rdata[RUN_BIT]          = det_en;
        bus_rdata[WIN_W-1:0]        = win_len;
      end
      A_RESULT: bus_rdata[RES_W-1:0] = result;
      A_REFEN:  bus_rdata[REFEN_BIT] = ref_en;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/fm_refcount.sv
module fm_refcount #(
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  logic             det_en,
  input  logic             ref_en,
  input  logic             done_lvl,
  output logic [RES_W-1:0] ref_cnt,
  output logic [RES_W-1:0] result,
  output logic             meas_active,
  output logic             done_pulse
);
  logic done_q;

  function automatic logic [RES_W-1:0] sat_inc(logic [RES_W-1:0] v);
    return (v == '1) ? v : v + RES_W'(1);
  endfunction

  assign done_pulse = done_lvl && !done_q && meas_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q      <= 1'b0;
      ref_cnt     <= '0;
      result      <= '0;
      meas_active <= 1'b0;
    end else begin
      done_q <= done_lvl;
      if (start_pulse) begin
        ref_cnt     <= '0;
        result      <= '0;
        meas_active <= 1'b1;
      end else if (!det_en) begin
        ref_cnt     <= '0;
        meas_active <= 1'b0;
      end else if (done_pulse) begin
        result      <= ref_cnt;
        meas_active <= 1'b0;
      end else if (meas_active && ref_en) begin
        ref_cnt <= sat_inc(ref_cnt);
      end
    end
  end
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import fm_pkg::*;
#(
  parameter int RES_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_clk,
  input  logic               bus_en,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata
);
  logic [SEL_W-1:0]   sel;
  logic               det_en, ref_en, start_pulse;
  logic [WIN_W-1:0]   win_len;
  logic [NUM_MON-1:0] mon_done;
  logic               done_lvl, meas_active, done_pulse;
  logic [RES_W-1:0]   ref_cnt, result;

  fm_regs #(.RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .result(result),
    .bus_rdata(bus_rdata), .sel(sel), .det_en(det_en), .win_len(win_len),
    .ref_en(ref_en), .start_pulse(start_pulse)
  );

  for (genvar i = 0; i < NUM_MON; i++) begin : g_win
    fm_window u_win (
      .mon_clk(mon_clk[i]), .rst_n(rst_n),
      .arm(det_en && (sel == SEL_W'(i))),
      .win_len(win_len), .win_done(mon_done[i])
    );
  end

  fm_sync2 u_done_sync (.clk(clk), .rst_n(rst_n), .d(mon_done[sel]), .q(done_lvl));

  fm_refcount #(.RES_W(RES_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .det_en(det_en),
    .ref_en(ref_en), .done_lvl(done_lvl), .ref_cnt(ref_cnt), .result(result),
    .meas_active(meas_active), .done_pulse(done_pulse)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int RES_W = 32,
  parameter int NUM_MON = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_pulse,
  input logic               det_en,
  input logic               ref_en,
  input logic [RES_W-1:0]   ref_cnt,
  input logic [RES_W-1:0]   result,
  input logic               meas_active,
  input logic               done_pulse,
  input logic [NUM_MON-1:0] mon_done
);
  AST_CAPTURE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !meas_active); // R3
  AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mon_done)); // R4
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> (result == '0 && ref_cnt == '0 && meas_active)); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_pulse && !done_pulse) |=> $stable(result)); // R6
  AST_STOP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !start_pulse) |=> !meas_active); // R6
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && !ref_en) |=> $stable(ref_cnt)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && ref_cnt == '1) |=> ref_cnt == '1); // R8
endmodule

bind clk_freq_meter fm_checker #(.RES_W(RES_W), .NUM_MON(fm_pkg::NUM_MON)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .det_en(det_en),
  .ref_en(ref_en), .ref_cnt(ref_cnt), .result(result),
  .meas_active(meas_active), .done_pulse(done_pulse), .mon_done(mon_done)
);

// File: tb/clk_freq_meter_test.sv
module clk_freq_meter_test;
  localparam int CLK_PERIOD = 10;
  localparam int MP0 = 30;
  localparam int MP1 = 14;
  localparam int MP2 = 50;
  localparam int RW  = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        m0 = 1'b0, m1 = 1'b0, m2 = 1'b0;
  logic [3:0]  mon_clk;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  int compared = 0, mismatched = 0;

  typedef struct { string req; int exp; int tol; } item_t;
  item_t sbq[$];

  assign mon_clk = {1'b0, m2, m1, m0};
  always #(CLK_PERIOD/2) clk = ~clk;
  always #(MP0/2) m0 = ~m0;
  always #(MP1/2) m1 = ~m1;
  always #(MP2/2) m2 = ~m2;

  clk_freq_meter #(.RES_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(string req, int got, int exp, int tol);
    compared++;
    if (got > exp + tol || got + tol < exp) begin
      mismatched++;
      $display("FAIL %s: got %0d (0x%08h) expected %0d (tol %0d)", req, got, got, exp, tol);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output int v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  function automatic int est(int n, int tm);
    return ((2*n + 3) * tm) / (2*CLK_PERIOD) + 1;
  endfunction

  function automatic logic [31:0] ctrl_word(int s, bit en, int n);
    return (32'(s) << 26) | (32'(en) << 24) | (32'(n) & 32'hFF_FFFF);
  endfunction

  // Driver: stop any run, set up, push the expectation, start.
  task automatic drive_meas(int s, int n, string req, int exp, int tol);
    item_t it;
    bus_write(2'd0, ctrl_word(s, 1'b0, n));
    repeat (20) @(negedge clk);
    it.req = req; it.exp = exp; it.tol = tol;
    sbq.push_back(it);
    bus_write(2'd0, ctrl_word(s, 1'b1, n));
  endtask

  // Monitor: poll the result word, pop the expectation and compare.
  task automatic collect(int limit, output int got);
    item_t it;
    got = 0;
    for (int c = 0; c < limit; c++) begin
      bus_read(2'd1, got);
      if (got != 0) break;
    end
    it = sbq.pop_front();
    check(it.req, got, it.exp, it.tol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int v, last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(2'd0, v); check("R1 ctrl", v, 0, 0);
    bus_read(2'd1, v); check("R1 result", v, 0, 0);
    bus_read(2'd2, v); check("R1 refen", v, 0, 0);

    bus_write(2'd0, 32'hFA12_3456 & ~32'h0100_0000);
    bus_read(2'd0, v); check("R2 ctrl fields", v, 32'h0812_3456, 0);
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, v); check("R2 refen bit8", v, 32'h0000_0100, 0);

    bus_write(2'd1, 32'h0000_0ABC);
    bus_read(2'd1, v); check("R10 result write ignored", v, 0, 0);

    drive_meas(0, 20, "R3 port0", est(20, MP0), MP0/CLK_PERIOD + 3);
    collect(300, v);
    drive_meas(1, 40, "R3 port1", est(40, MP1), MP1/CLK_PERIOD + 3);
    collect(300, v);
    drive_meas(2, 10, "R4 port2", est(10, MP2), MP2/CLK_PERIOD + 3);
    collect(300, last);

    bus_write(2'd0, ctrl_word(2, 1'b0, 10));
    repeat (50) @(negedge clk);
    bus_read(2'd1, v); check("R6 result kept after clear", v, last, 0);
    bus_read(2'd0, v); check("R6 enable cleared", (v >> 24) & 1, 0, 0);

    drive_meas(2, 300, "R8 saturate", (1 << RW) - 1, 0);
    bus_read(2'd1, v); check("R5 result cleared on start", v, 0, 0);
    repeat (100) @(negedge clk);
    bus_read(2'd1, v); check("R5 zero while running", v, 0, 0);
    collect(2500, v);

    bus_write(2'd2, 32'h0);
    drive_meas(0, 20, "R7 reference gated", 0, 0);
    collect(400, v);
    bus_write(2'd2, 32'h100);

    drive_meas(3, 20, "R9 stopped clock", 0, 0);
    collect(400, v);
    drive_meas(0, 0, "R9 zero window", 0, 0);
    collect(400, v);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule